// File: doc/BRIEF.md
# MIDI Serial Port

This block is a fixed-format asynchronous serial port for the 31.25 kbit/s musical-instrument link. It sends and receives ten-bit frames, each made of a low start bit, eight data bits sent least-significant bit first, and a high stop bit. The idle line is high. The bit timing comes from a fixed two-stage chain. A reference divider turns the system clock into a 500 kHz tick. Each bit then lasts sixteen of those ticks, and the receiver uses the sixteen ticks as oversampling points.

Software drives the port through a two-register window and either polls a status byte or waits on an interrupt line. Writing the data address while the transmitter is idle starts a frame. Reading the data address returns the last received byte and acknowledges it. The raw serial input is also copied unchanged to a thru output, so that further instruments can be chained. The interrupt request is the OR of two flags: "byte received" and "transmission complete".

Top module: `midi_port`

## Requirements
- R1: A reference tick occurs once every REF_DIV system clocks. Every transmitted bit lasts exactly 16 reference ticks (16*REF_DIV clocks), except the start bit, which may be shorter by less than one tick.
- R2: A write to address 1 while the transmitter is idle sends one frame on `txOut`: a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. `txOut` is 1 whenever no frame is being sent.
- R3: Status bit 1 (transmitter empty) reads 0 from the write that starts a frame until the stop bit ends. It reads 1 at all other times.
- R4: A write to address 1 while a frame is being sent is ignored. The frame in progress is unchanged, and no second frame follows it.
- R5: Status bit 2 (transmission complete) is set when the stop bit ends, and it raises `irq`. A write that starts the next frame clears it.
- R6: The receiver treats a low level on `rxIn` as a start bit only if `rxIn` is still low at the 8th reference tick. A low pulse shorter than half a bit is discarded and delivers no byte.
- R7: After a received frame's stop-bit sample, the eight data bits, taken least-significant bit first, appear at address 1. Status bit 7 (receive full) is set and `irq` rises.
- R8: A read of address 1 clears status bit 7 and removes its contribution to `irq`.
- R9: A stop bit sampled as 0 sets status bit 4 (framing error) and still delivers the byte. The next frame with a good stop bit clears bit 4. After a bad stop bit, the receiver waits for the line to return high before it looks for a new start bit.
- R10: `thruOut` always equals `rxIn`.
- R11: After reset the status byte (address 0) reads 0x02, address 1 reads 0x00, `txOut` is 1 and `irq` is 0.
- R12: Writes to addresses 0, 2 and 3 have no effect. Reads of addresses 2 and 3 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regAddr | input | 2 | Register select: 0 status, 1 data |
| regWrEn | input | 1 | Single-cycle write strobe |
| regRdEn | input | 1 | Single-cycle read strobe (used for the read side effect) |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from `regAddr` |
| rxIn | input | 1 | Serial receive line |
| txOut | output | 1 | Serial transmit line |
| thruOut | output | 1 | Copy of `rxIn` |
| irq | output | 1 | Interrupt request: receive full or transmission complete |

## Verification
The properties assume that each access strobe lasts one cycle, and that a read and a write are never asserted together. They also assume that `rxIn` keeps each level for whole bit periods at the configured rate, apart from deliberate short glitches. The stimulus meets these assumptions. It changes every input only on falling clock edges. It builds each received bit from exactly 16*REF_DIV clocks, and it raises each strobe for one clock only. The one short low pulse it applies is kept well under half a bit, so the start-bit check can reject it.

// File: rtl/midi_pkg.sv
`timescale 1ns/1ps
package midi_pkg;

  localparam int DATA_BITS = 8;
  localparam int FRAME_BITS = DATA_BITS + 2;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_DATA   = 2'd1;

  localparam int ST_RX_FULL  = 7;
  localparam int ST_FRAME_ERR = 4;
  localparam int ST_TX_DONE  = 2;
  localparam int ST_TX_EMPTY = 1;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic txFinish;
    logic rxShift;
    logic rxCommit;
    logic rxRead;
  } strobe_t;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_HOLD
  } rx_state_t;

endpackage

// File: rtl/midi_ref_div.sv
`timescale 1ns/1ps
module midi_ref_div #(
  parameter int REF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic refTick
);

  localparam int CW = (REF_DIV > 1) ? $clog2(REF_DIV) : 1;

  generate
    if (REF_DIV <= 1) begin : gen_bypass
      assign refTick = rst_n;
    end else begin : gen_count
      logic [CW-1:0] refCnt;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          refCnt <= '0;
        end else if (refCnt == CW'(REF_DIV - 1)) begin
          refCnt <= '0;
        end else begin
          refCnt <= refCnt + 1'b1;
        end
      end
      assign refTick = (refCnt == CW'(REF_DIV - 1));
    end
  endgenerate

endmodule

// File: rtl/midi_ctrl.sv
`timescale 1ns/1ps
module midi_ctrl
  import midi_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refTick,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic       rxLine,
  output strobe_t    stb,
  output logic       txBusy
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int HALF  = OVERSAMPLE / 2;
  localparam int TXI_W = $clog2(FRAME_BITS);
  localparam int RXI_W = $clog2(DATA_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST  = CNT_W'(OVERSAMPLE - 1);
  localparam logic [CNT_W-1:0] CNT_HALF  = CNT_W'(HALF - 1);
  localparam logic [TXI_W-1:0] TXI_LAST  = TXI_W'(FRAME_BITS - 1);
  localparam logic [RXI_W-1:0] RXI_LAST  = RXI_W'(DATA_BITS - 1);

  // transmit sequencing
  logic [CNT_W-1:0] txCnt;
  logic [TXI_W-1:0] txIdx;
  logic             txBitEnd;

  // receive sequencing
  rx_state_t        rxState;
  logic [CNT_W-1:0] rxCnt;
  logic [RXI_W-1:0] rxIdx;
  logic             rxAtEnd;

  always_comb begin
    txBitEnd     = txBusy && refTick && (txCnt == CNT_LAST);
    rxAtEnd      = refTick && (rxCnt == CNT_LAST);
    stb.txLoad   = regWrEn && (regAddr == ADDR_DATA) && !txBusy;
    stb.txShift  = txBitEnd && (txIdx != TXI_LAST);
    stb.txFinish = txBitEnd && (txIdx == TXI_LAST);
    stb.rxShift  = (rxState == RX_DATA) && rxAtEnd;
    stb.rxCommit = (rxState == RX_STOP) && rxAtEnd;
    stb.rxRead   = regRdEn && (regAddr == ADDR_DATA);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
      txIdx  <= '0;
    end else if (stb.txLoad) begin
      txBusy <= 1'b1;
      txCnt  <= '0;
      txIdx  <= '0;
    end else if (txBusy && refTick) begin
      if (txCnt == CNT_LAST) begin
        txCnt <= '0;
        if (txIdx == TXI_LAST) begin
          txBusy <= 1'b0;
        end else begin
          txIdx <= txIdx + 1'b1;
        end
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxIdx   <= '0;
    end else begin
      case (rxState)
        RX_IDLE: begin
          if (refTick && !rxLine) begin
            rxState <= RX_START;
            rxCnt   <= '0;
          end
        end
        RX_START: begin
          if (refTick) begin
            if (rxCnt == CNT_HALF) begin
              rxCnt <= '0;
              rxIdx <= '0;
              rxState <= rxLine ? RX_IDLE : RX_DATA;
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (refTick) begin
            if (rxCnt == CNT_LAST) begin
              rxCnt <= '0;
              if (rxIdx == RXI_LAST) begin
                rxState <= RX_STOP;
              end else begin
                rxIdx <= rxIdx + 1'b1;
              end
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (refTick) begin
            if (rxCnt == CNT_LAST) begin
              rxCnt   <= '0;
              rxState <= rxLine ? RX_IDLE : RX_HOLD;
            end else begin
              rxCnt <= rxCnt + 1'b1;
            end
          end
        end
        RX_HOLD: begin
          if (rxLine) begin
            rxState <= RX_IDLE;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/midi_datapath.sv
`timescale 1ns/1ps
module midi_datapath
  import midi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  strobe_t              stb,
  input  logic [1:0]           regAddr,
  input  logic [DATA_BITS-1:0] regWrData,
  input  logic                 rxIn,
  input  logic                 txBusy,
  output logic                 txOut,
  output logic                 rxLine,
  output logic                 rxFull,
  output logic                 txDone,
  output logic [7:0]           regRdData
);

  logic                  rxMeta;
  logic [FRAME_BITS-1:0] txFrame;
  logic [DATA_BITS-1:0]  rxShreg;
  logic [DATA_BITS-1:0]  rxData;
  logic                  frameErr;
  logic [7:0]            statusByte;

  // two-flop synchroniser on the serial input
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxMeta <= 1'b1;
      rxLine <= 1'b1;
    end else begin
      rxMeta <= rxIn;
      rxLine <= rxMeta;
    end
  end

  // transmit frame: bit 0 is on the line, ones fill from the top
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txFrame <= '1;
    end else if (stb.txLoad) begin
      txFrame <= {1'b1, regWrData, 1'b0};
    end else if (stb.txShift) begin
      txFrame <= {1'b1, txFrame[FRAME_BITS-1:1]};
    end
  end
  assign txOut = txFrame[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxShreg <= '0;
    end else if (stb.rxShift) begin
      rxShreg <= {rxLine, rxShreg[DATA_BITS-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxData   <= '0;
      rxFull   <= 1'b0;
      frameErr <= 1'b0;
    end else if (stb.rxCommit) begin
      rxData   <= rxShreg;
      rxFull   <= 1'b1;
      frameErr <= !rxLine;
    end else if (stb.rxRead) begin
      rxFull <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txDone <= 1'b0;
    end else if (stb.txFinish) begin
      txDone <= 1'b1;
    end else if (stb.txLoad) begin
      txDone <= 1'b0;
    end
  end

  always_comb begin
    statusByte               = '0;
    statusByte[ST_RX_FULL]   = rxFull;
    statusByte[ST_FRAME_ERR] = frameErr;
    statusByte[ST_TX_DONE]   = txDone;
    statusByte[ST_TX_EMPTY]  = !txBusy;
    case (regAddr)
      ADDR_STATUS: regRdData = statusByte;
      ADDR_DATA:   regRdData = rxData;
      default:     regRdData = '0;
    endcase
  end

endmodule

// File: rtl/midi_port.sv
`timescale 1ns/1ps
module midi_port
  import midi_pkg::*;
#(
  parameter int REF_DIV    = 2,
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] regAddr,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       rxIn,
  output logic       txOut,
  output logic       thruOut,
  output logic       irq
);

  logic    refTick;
  logic    rxLine;
  logic    txBusy;
  logic    rxFull;
  logic    txDone;
  strobe_t stb;

  midi_ref_div #(.REF_DIV(REF_DIV)) refdiv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .refTick (refTick)
  );

  midi_ctrl #(.OVERSAMPLE(OVERSAMPLE)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .refTick (refTick),
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .rxLine  (rxLine),
    .stb     (stb),
    .txBusy  (txBusy)
  );

  midi_datapath dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .rxIn      (rxIn),
    .txBusy    (txBusy),
    .txOut     (txOut),
    .rxLine    (rxLine),
    .rxFull    (rxFull),
    .txDone    (txDone),
    .regRdData (regRdData)
  );

  assign thruOut = rxIn;
  assign irq     = rxFull | txDone;

endmodule

// File: rtl/midi_port_chk.sv
`timescale 1ns/1ps
module midi_port_chk
  import midi_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input strobe_t    stb,
  input logic       txBusy,
  input logic       txOut,
  input logic       rxFull,
  input logic       irq,
  input logic [1:0] regAddr,
  input logic       regWrEn
);

  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !txBusy |-> txOut);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.txLoad |=> !txOut);

  assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stb.txFinish |-> txOut);

  assert_tx_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.txLoad, stb.txShift, stb.txFinish}));

  assert_busy_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (txBusy && regWrEn && regAddr == ADDR_DATA && !stb.txFinish) |=> txBusy);

  assert_done_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.txFinish |=> irq);

  assert_rx_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rxCommit |=> (rxFull && irq));

  assert_rx_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxFull) |-> $past(stb.rxCommit));

  assert_read_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rxRead && !stb.rxCommit) |=> !rxFull);

endmodule

bind midi_port midi_port_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .stb     (stb),
  .txBusy  (txBusy),
  .txOut   (txOut),
  .rxFull  (rxFull),
  .irq     (irq),
  .regAddr (regAddr),
  .regWrEn (regWrEn)
);

// File: tb/midi_port_tb.sv
`timescale 1ns/1ps
module midi_port_tb_top;

  localparam int REF_DIV = 3;
  localparam int BIT     = 16 * REF_DIV;
  localparam int NVEC    = 5;

  // {tx byte, rx byte, rx stop bit}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'h00, 8'hFF, 1'b1},
    {8'hA5, 8'h3C, 1'b1},
    {8'h81, 8'h5A, 1'b0},
    {8'hFF, 8'h00, 1'b1},
    {8'h6E, 8'hC3, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       rxIn = 1'b1;
  logic       txOut;
  logic       thruOut;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit txDoneExp = 0;

  always #2 clk = ~clk;

  midi_port #(.REF_DIV(REF_DIV)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regRdEn   (regRdEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .rxIn      (rxIn),
    .txOut     (txOut),
    .thruOut   (thruOut),
    .irq       (irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic regRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr   = a;
    regWrData = d;
    regWrEn   = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] d, input logic stopBit);
    @(negedge clk);
    rxIn = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxIn = d[i];
      repeat (BIT) @(negedge clk);
    end
    rxIn = stopBit;
    repeat (BIT) @(negedge clk);
    rxIn = 1'b1;
    repeat (BIT) @(negedge clk);
  endtask

  task automatic txCapture(output logic [7:0] d, output logic s0, output logic s9);
    repeat (BIT/2 - 1) @(negedge clk);
    s0 = txOut;
    for (int i = 0; i < 8; i++) begin
      repeat (BIT) @(negedge clk);
      d[i] = txOut;
    end
    repeat (BIT) @(negedge clk);
    s9 = txOut;
  endtask

  task automatic waitTxDone(output bit ok);
    logic [7:0] st;
    ok = 0;
    for (int n = 0; n < 10 * BIT; n++) begin
      regRead(2'd0, st);
      if (st[2]) begin
        ok = 1;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] txb;
    logic s0;
    logic s9;
    bit ok;
    int cyc;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R11 reset state
    regRead(2'd0, rd);
    chk("R11 status after reset", rd, 8'h02);
    regRead(2'd1, rd);
    chk("R11 data after reset", rd, 8'h00);
    chk("R11 txOut after reset", txOut, 1'b1);
    chk("R11 irq after reset", irq, 1'b0);

    // R12 other addresses
    regWrite(2'd0, 8'h55);
    regWrite(2'd2, 8'h55);
    regWrite(2'd3, 8'h55);
    regRead(2'd2, rd);
    chk("R12 read addr 2", rd, 8'h00);
    regRead(2'd3, rd);
    chk("R12 read addr 3", rd, 8'h00);
    repeat (BIT) @(negedge clk);
    chk("R12 no frame from other addresses", txOut, 1'b1);
    regRead(2'd0, rd);
    chk("R12 status unchanged", rd, 8'h02);

    // R10 thru mirror
    rxIn = 1'b0;
    #1 chk("R10 thru low", thruOut, 1'b0);
    rxIn = 1'b1;
    #1 chk("R10 thru high", thruOut, 1'b1);

    // vector table walk
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] txv;
      logic [7:0] rxv;
      logic stopv;
      logic [7:0] expSt;
      {txv, rxv, stopv} = VEC[v];

      sendRx(rxv, stopv);
      expSt = 8'h82 | (stopv ? 8'h00 : 8'h10) | (txDoneExp ? 8'h04 : 8'h00);
      regRead(2'd0, rd);
      chk(stopv ? "R7 status after rx" : "R9 status after bad stop", rd, expSt);
      chk("R7 irq after rx", irq, 1'b1);
      regRead(2'd1, rd);
      chk(stopv ? "R7 rx data" : "R9 rx data with bad stop", rd, rxv);
      regRead(2'd0, rd);
      chk("R8 status bit7 clear after read", rd[7], 1'b0);
      chk("R8 irq after data read", irq, txDoneExp);

      regWrite(2'd1, txv);
      txDoneExp = 0;
      regRead(2'd0, rd);
      chk("R3 tx empty low while sending", rd[1], 1'b0);
      chk("R5 tx done cleared by write", rd[2], 1'b0);
      txCapture(txb, s0, s9);
      chk("R2 start bit", s0, 1'b0);
      chk("R2 data bits", txb, txv);
      chk("R2 stop bit", s9, 1'b1);
      waitTxDone(ok);
      txDoneExp = 1;
      chk("R5 tx done set", ok, 1'b1);
      chk("R5 irq on tx done", irq, 1'b1);
      regRead(2'd0, rd);
      chk("R3 tx empty after frame", rd[1], 1'b1);
    end

    // R1 bit period: byte 0x02 gives 0,0,1,0 after start
    regWrite(2'd1, 8'h02);
    txDoneExp = 0;
    while (txOut == 1'b0) @(negedge clk);
    cyc = 0;
    while (txOut == 1'b1 && cyc < 4 * BIT) begin
      @(negedge clk);
      cyc++;
    end
    chk("R1 bit period in clocks", 16'(cyc), 16'(BIT));
    waitTxDone(ok);
    txDoneExp = 1;

    // R4 write while busy is ignored
    regWrite(2'd1, 8'h5A);
    txDoneExp = 0;
    repeat (3 * BIT) @(negedge clk);
    regWrite(2'd1, 8'h0F);
    regRead(2'd0, rd);
    chk("R4 still busy after second write", rd[2:1], 2'b00);
    waitTxDone(ok);
    txDoneExp = 1;
    chk("R4 first frame completes", ok, 1'b1);
    begin
      bit stayedHigh;
      stayedHigh = 1;
      for (int i = 0; i < 3 * BIT; i++) begin
        @(negedge clk);
        if (txOut !== 1'b1) stayedHigh = 0;
      end
      chk("R4 no second frame", stayedHigh, 1'b1);
    end
    regRead(2'd0, rd);
    chk("R4 tx empty after ignored write", rd[1], 1'b1);

    // R6 short low glitch is rejected
    @(negedge clk);
    rxIn = 1'b0;
    repeat (BIT/4) @(negedge clk);
    rxIn = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    regRead(2'd0, rd);
    chk("R6 glitch gives no byte", rd[7], 1'b0);
    regRead(2'd1, rd);
    chk("R6 data unchanged after glitch", rd, 8'hC3);

    // R9 framing error set then cleared by good frame
    sendRx(8'h96, 1'b0);
    regRead(2'd0, rd);
    chk("R9 frame error set", rd[4], 1'b1);
    regRead(2'd1, rd);
    chk("R9 byte delivered", rd, 8'h96);
    sendRx(8'h21, 1'b1);
    regRead(2'd0, rd);
    chk("R9 frame error cleared by good frame", rd[4], 1'b0);
    regRead(2'd1, rd);
    chk("R9 next byte after bad stop", rd, 8'h21);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule